// File: doc/BRIEF.md
# Bi-phase level serial line decoder

This block turns a bi-phase level (Manchester) coded serial line into a stream of data bits. A system clock oversamples the line at a fixed, known number of clocks per nominal bit cell. Every cell carries a transition at its centre. The direction of that centre transition gives the bit: with the default mapping, low-to-high is 1 and high-to-low is 0. A transition at the edge between two cells appears only when two equal bits follow each other, and it carries no data.

The decoder uses no recovered clock. Once it accepts a centre transition, it ignores the line for three quarters of a nominal cell, so any cell-edge transition falls inside that dead time. The first transition after the dead time is taken as the next centre transition. A missing centre transition, one and a quarter cells long, raises an error pulse and drops the block back to hunting. In hunting, the next transition of any kind is accepted as a centre transition. The input must already be synchronized to the clock.

Top module: `biphase_level_rx`

## Requirements
- R1: After reset `bit_o`, `valid_o` and `err_o` are 0. While the line holds a constant level, no strobe and no error appear, including when the line is already high as reset is released.
- R2: With `RISE_IS_ONE`=1, a low-to-high centre transition decodes as `bit_o`=1 and a high-to-low one as 0. With `RISE_IS_ONE`=0 the mapping is inverted.
- R3: `valid_o` is high for exactly one clock per decoded cell, and `bit_o` is valid in that clock. The strobe appears in the clock after the edge at which the changed line level is first sampled.
- R4: Transitions that occur fewer than BLANK = 3*`CLKS_PER_BIT`/4 clocks after an accepted centre transition are ignored. This covers cell-edge transitions and short glitches.
- R5: Cells between 0.75 and 1.25 times `CLKS_PER_BIT` clocks long decode without error.
- R6: If no transition arrives within LIMIT = 5*`CLKS_PER_BIT`/4 clocks of the last accepted centre transition, `err_o` pulses for one clock. The pulse comes exactly LIMIT clocks after the matching `valid_o` strobe, and never together with `valid_o`.
- R7: After an error, the next transition is accepted as a centre transition, and decoding resumes from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Synchronized coded serial line |
| bit_o | output | 1 | Decoded bit, valid with `valid_o` |
| valid_o | output | 1 | One-clock strobe per decoded bit |
| err_o | output | 1 | One-clock pulse on a missing centre transition |

## Verification
If the block locks onto cell-edge transitions instead of centre transitions, `bit_o` shows the wrong value within one cell. The strobe count also drifts away from the number of cells sent. A wrong dead-time or timeout count shows up the same way at the ends of the tolerance window: cells 0.75 or 1.25 times nominal length either drop strobes or produce false error pulses. The bench also measures the distance in clocks from the last strobe to the error pulse, so an off-by-one in the timeout is visible at the ports.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
  typedef enum logic {HUNT = 1'b0, LOCK = 1'b1} rx_state_e;

  // dead time after an accepted centre transition
  function automatic int blank_clks(input int n);
    return (n * 3) / 4;
  endfunction

  // longest wait for the next centre transition
  function automatic int limit_clks(input int n);
    return (n * 5) / 4;
  endfunction

  // level after the transition -> data bit
  function automatic logic bit_from_level(input logic level, input bit rise_one);
    return rise_one ? level : ~level;
  endfunction
endpackage

// File: rtl/bpl_edge.sv
module bpl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic edge_o
);
  logic armed;
  logic line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      line_q <= 1'b0;
    end else begin
      armed  <= 1'b1;
      line_q <= line_i;
    end
  end

  assign edge_o = armed && (line_i != line_q);
endmodule

// File: rtl/bpl_timer.sv
module bpl_timer #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic open_o,
  output logic expired_o
);
  import bpl_pkg::*;
  localparam int BLANK = blank_clks(CLKS_PER_BIT);
  localparam int LIMIT = limit_clks(CLKS_PER_BIT);
  localparam int CW    = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] BLANK_C = CW'(BLANK);
  localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (restart_i)    cnt <= CW'(1);
    else if (cnt < LIMIT_C) cnt <= cnt + CW'(1);
  end

  assign open_o    = (cnt >= BLANK_C);
  assign expired_o = (cnt >= LIMIT_C);
endmodule

// File: rtl/biphase_level_rx.sv
module biphase_level_rx #(
  parameter int CLKS_PER_BIT = 16,
  parameter bit RISE_IS_ONE  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic bit_o,
  output logic valid_o,
  output logic err_o
);
  import bpl_pkg::*;

  rx_state_e state;
  logic      line_edge;
  logic      win_open;
  logic      win_expired;
  logic      accept;
  logic      timeout;

  bpl_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .edge_o (line_edge)
  );

  bpl_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (accept),
    .open_o    (win_open),
    .expired_o (win_expired)
  );

  assign accept  = line_edge && ((state == HUNT) || win_open);
  assign timeout = (state == LOCK) && !line_edge && win_expired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= HUNT;
      bit_o   <= 1'b0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= accept;
      err_o   <= timeout;
      if (accept) begin
        bit_o <= bit_from_level(line_i, RISE_IS_ONE);
        state <= LOCK;
      end else if (timeout) begin
        state <= HUNT;
      end
    end
  end
endmodule

// File: rtl/biphase_level_rx_chk.sv
module biphase_level_rx_chk #(
  parameter int CLKS_PER_BIT = 16,
  parameter bit RISE_IS_ONE  = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic line_i,
  input logic bit_o,
  input logic valid_o,
  input logic err_o
);
  import bpl_pkg::*;
  localparam int BLANK = blank_clks(CLKS_PER_BIT);
  localparam int LIMIT = limit_clks(CLKS_PER_BIT);
  localparam int SW    = $clog2(LIMIT + 3);
  localparam logic [SW-1:0] TOP_C = SW'(LIMIT + 1);

  logic [SW-1:0] since_v;

  always_ff @(posedge clk) begin
    if (!rst_n)           since_v <= TOP_C;
    else if (valid_o)     since_v <= SW'(1);
    else if (since_v < TOP_C) since_v <= since_v + SW'(1);
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R4
  blank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(since_v) >= BLANK));

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R6
  err_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!valid_o && int'(since_v) == LIMIT));

  // R2
  bit_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(line_i) != $past(line_i, 2)) &&
                (bit_o == (RISE_IS_ONE ? $past(line_i) : !$past(line_i))));
endmodule

bind biphase_level_rx biphase_level_rx_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT), .RISE_IS_ONE(RISE_IS_ONE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_i(line_i),
  .bit_o(bit_o), .valid_o(valid_o), .err_o(err_o)
);

// File: tb/sim_biphase_level_rx.sv
module sim_biphase_level_rx;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 16;
  localparam int LIMIT = (N * 5) / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic bit0, val0, err0, bit1, val1, err1;

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [63:0] rx0, rx1;
  int n0, n1, e0, dbl, last_v_cyc, err_cyc;
  logic prev_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  biphase_level_rx #(.CLKS_PER_BIT(N), .RISE_IS_ONE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line), .bit_o(bit0), .valid_o(val0), .err_o(err0));
  biphase_level_rx #(.CLKS_PER_BIT(N), .RISE_IS_ONE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .line_i(line), .bit_o(bit1), .valid_o(val1), .err_o(err1));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (val0) begin rx0[n0] = bit0; n0 = n0 + 1; last_v_cyc = cyc; end
    if (val1) begin rx1[n1] = bit1; n1 = n1 + 1; end
    if (val0 && prev_v) dbl = dbl + 1;
    if (err0) begin e0 = e0 + 1; err_cyc = cyc; end
    prev_v = val0;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    line = lvl;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic first_half(input logic b);
    return ~b;  // bit 1 = low then high (rising at centre)
  endfunction

  task automatic clear_mon();
    n0 = 0; n1 = 0; e0 = 0; dbl = 0; rx0 = '0; rx1 = '0; err_cyc = 0; last_v_cyc = 0;
  endtask

  task automatic burst(input int len, input int nb, input int glitch_at, input string tag);
    logic [63:0] bits, mask;
    int h;
    bits = {$urandom, $urandom};
    mask = (nb == 64) ? '1 : ((64'd1 << nb) - 64'd1);
    bits = bits & mask;
    h = len / 2;
    hold(first_half(bits[0]), 3 * N);
    clear_mon();
    for (int i = 0; i < nb; i++) begin
      hold(first_half(bits[i]), h);
      if (i == glitch_at) begin
        hold(~first_half(bits[i]), 3);
        hold(first_half(bits[i]), 2);
        hold(~first_half(bits[i]), len - h - 5);
      end else begin
        hold(~first_half(bits[i]), len - h);
      end
    end
    repeat (3 * N) @(negedge clk);
    check({tag, " R3 strobe count"}, 64'(n0), 64'(nb));
    check({tag, " R3 single-clock strobe"}, 64'(dbl), 64'd0);
    check({tag, " R2/R5 bits"}, rx0 & mask, bits);
    check({tag, " R2 inverted bits"}, rx1 & mask, ~bits & mask);
    check({tag, " R6 one error at end"}, 64'(e0), 64'd1);
    check({tag, " R6 error latency"}, 64'(err_cyc - last_v_cyc), 64'(LIMIT));
  endtask

  initial begin
    int wd_fail;
    wd_fail = 0;
    clear_mon();
    prev_v = 1'b0;
    void'($urandom(32'd2024));
    line = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid in reset", 64'(val0), 64'd0);
    rst_n = 1'b1;
    repeat (2 * LIMIT + 10) @(negedge clk);
    check("R1 no strobe on constant high", 64'(n0), 64'd0);
    check("R1 no error on constant high", 64'(e0), 64'd0);
    check("R1 bit_o/err_o idle", {62'd0, bit0, err0}, 64'd0);
    // R5 tolerance edges and nominal; R7 every burst re-acquires after the previous error
    burst(16, 24, -1, "nominal");
    burst(12, 24, -1, "fast-25%");
    burst(20, 24, -1, "slow+25%");
    burst(14, 32, -1, "fast");
    burst(18, 32, -1, "slow");
    // R4 glitch inside dead time ignored
    burst(16, 16, 5, "glitch");
    burst(16, 16, 0, "glitch-first");
    // R7 random rates after repeated errors
    for (int k = 0; k < 6; k++) burst(12 + 2 * int'($urandom % 5), 8 + int'($urandom % 40), -1, "R7 random");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails + wd_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
    $finish;
  end
endmodule